// File: doc/BRIEF.md
# Multi-CPU Device Interrupt Router

This block takes up to 64 device interrupt requests and routes them to four processors. All requesters share one raw request vector. Other logic sets bits in that vector with a post pulse and removes them with a clear pulse. Each processor has its own mask register and its own result register, which holds the requests that have been routed to it. A sticky per-processor flag drives that processor's interrupt line. A miscellaneous register reports the number of the processor making the access, and it also holds a real-time-clock interrupt that software clears by writing to it.

Software reaches the block over a simple register bus. Each access carries a CPU id, an address, a size code and 64-bit write data. The block samples an access on a rising edge. The response (read data and an error flag) is registered and valid in the cycle that follows. Registers sit on 64-byte strides, and address bits below bit 6 are ignored.

Top module: `irq_route_hub`

## Requirements
- R1: While reset is low, all masks, result registers, the raw vector, the per-CPU flags and the RTC flag clear, so every `cpu_irq` line and `rtc_irq` are low.
- R2: Only size code 2'b11 (a 64-bit access) is accepted. Any other size code raises the error flag, and the access changes no state.
- R3: A write to the status register, the raw vector register or any result register raises the error flag and changes nothing. The raw vector changes only through the post and clear pulses.
- R4: A read of the status register returns zero without an error.
- R5: A read of the miscellaneous register returns the RTC flag in bit 4, ORed with the 2-bit CPU id of the access in bits [1:0].
- R6: A pulse on `rtc_set` sets the RTC flag and raises `rtc_irq`. A write to the miscellaneous register with bit 4 set clears the flag. A write with bit 4 clear is an error and changes nothing. When a set and a clear land in the same cycle, the set wins.
- R7: Writing mask n stores the new mask. If the new mask ANDed with the raw vector is nonzero, result n is loaded with that AND and CPU n's flag is set. Otherwise result n and the flag keep their values.
- R8: A post pulse ORs its vector into the raw vector. Every CPU whose mask overlaps the vector has the whole vector ORed into its result register, and its flag is set.
- R9: A clear pulse removes its bits from the raw vector and from every result register. Every CPU whose result register is zero after this loses its flag.
- R10: A set flag stays set until a clear pulse leaves that CPU's result register at zero. Mask writes, including a write of an all-zero mask, never drop it.
- R11: When a mask write, a post and a clear fall in the same cycle, they take effect in that order. The mask write compares against the raw vector as it was before the post, and the post compares against the new mask.
- R12: The register index is address bits [ADDR_W-1:6]. Index 0 is the status register, 1 the miscellaneous register, 2 the raw vector, 4+n mask n and 8+n result n. Any other index raises the error flag. An errored access reads as zero, and the error flag is high only in the cycle after the erroring access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | 2 | Id of the CPU making the access |
| bus_size | input | 2 | Access size code, 2'b11 = 64-bit |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| bus_err | output | 1 | Registered error flag for the previous access |
| post_valid | input | 1 | Post pulse |
| post_vec | input | 64 | Request bits to post |
| clear_valid | input | 1 | Clear pulse |
| clear_vec | input | 64 | Request bits to clear |
| rtc_set | input | 1 | Raises the RTC interrupt |
| cpu_irq | output | NCPU | One interrupt line per CPU |
| rtc_irq | output | 1 | Real-time-clock interrupt line |

## Verification
The assertions check on every cycle that:
- reset forces the lines low;
- a narrow access always errors;
- an error follows an access and reads as zero;
- the raw vector holds still without pulses;
- the RTC line follows set and write-clear;
- a per-CPU line rises after an overlapping post and falls only after a clear.

Only the bench's scenarios can show the exact register contents: the whole-vector merge on a post, the load-on-mask-write rule and the same-cycle ordering of mask write, post and clear. The same goes for the CPU id in the miscellaneous readback, and for proof that rejected writes left the readable state untouched.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int DATA_W        = 64;
  localparam int CPU_ID_W      = 2;
  localparam int STRIDE_LSB    = 6;
  localparam int RTC_BIT       = 4;

  localparam logic [1:0] SIZE_DWORD = 2'b11;

  // register index map (index = address >> STRIDE_LSB)
  localparam int IDX_CTRL      = 0;
  localparam int IDX_MISC      = 1;
  localparam int IDX_RAW       = 2;
  localparam int IDX_MASK_BASE = 4;
  localparam int IDX_RES_BASE  = 8;

  typedef enum logic [2:0] {
    K_NONE,
    K_CTRL,
    K_MISC,
    K_RAW,
    K_MASK,
    K_RES
  } reg_kind_e;

  function automatic logic overlaps(input logic [DATA_W-1:0] a,
                                    input logic [DATA_W-1:0] b);
    return |(a & b);
  endfunction

  function automatic logic [DATA_W-1:0] merge_bits(input logic [DATA_W-1:0] a,
                                                   input logic [DATA_W-1:0] b);
    return a | b;
  endfunction

  function automatic logic [DATA_W-1:0] strip_bits(input logic [DATA_W-1:0] a,
                                                   input logic [DATA_W-1:0] b);
    return a & ~b;
  endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_route_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 12
) (
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [1:0]           bus_size,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 wbit_rtc,
  output reg_kind_e            kind,
  output logic [((NCPU > 1) ? $clog2(NCPU) : 1)-1:0] lane,
  output logic                 acc_err,
  output logic [NCPU-1:0]      mask_we,
  output logic                 misc_clr
);

  localparam int IDX_W  = ADDR_W - STRIDE_LSB;
  localparam int LANE_W = (NCPU > 1) ? $clog2(NCPU) : 1;

  logic [IDX_W-1:0] idx;
  logic             bad;
  logic             ok_wr;

  always_comb begin
    idx  = bus_addr[ADDR_W-1:STRIDE_LSB];
    kind = K_NONE;
    lane = '0;
    if (idx == IDX_W'(IDX_CTRL))      kind = K_CTRL;
    else if (idx == IDX_W'(IDX_MISC)) kind = K_MISC;
    else if (idx == IDX_W'(IDX_RAW))  kind = K_RAW;
    for (int i = 0; i < NCPU; i++) begin
      if (idx == IDX_W'(IDX_MASK_BASE + i)) begin
        kind = K_MASK;
        lane = LANE_W'(i);
      end
      if (idx == IDX_W'(IDX_RES_BASE + i)) begin
        kind = K_RES;
        lane = LANE_W'(i);
      end
    end
  end

  always_comb begin
    bad = 1'b0;
    if (bus_size != SIZE_DWORD) begin
      bad = 1'b1;
    end else begin
      case (kind)
        K_NONE:             bad = 1'b1;
        K_CTRL, K_RAW, K_RES: bad = bus_write;
        K_MISC:             bad = bus_write && !wbit_rtc;
        default:            bad = 1'b0;
      endcase
    end
    acc_err  = bus_valid && bad;
    ok_wr    = bus_valid && bus_write && !bad;
    misc_clr = ok_wr && (kind == K_MISC);
    for (int i = 0; i < NCPU; i++) begin
      mask_we[i] = ok_wr && (kind == K_MASK) && (lane == LANE_W'(i));
    end
  end

endmodule

// File: rtl/irq_cpu_lane.sv
module irq_cpu_lane
  import irq_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] raw_q,
  input  logic              post_valid,
  input  logic [DATA_W-1:0] post_vec,
  input  logic              clear_valid,
  input  logic [DATA_W-1:0] clear_vec,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] res_q,
  output logic              irq_q,
  output logic              load_hit,
  output logic              post_hit
);

  logic [DATA_W-1:0] mask_n;
  logic [DATA_W-1:0] res_load;
  logic [DATA_W-1:0] res_post;
  logic [DATA_W-1:0] res_n;
  logic              flag_n;

  // stage order: mask write, then post, then clear
  always_comb begin
    mask_n   = mask_we ? wdata : mask_q;
    load_hit = mask_we && overlaps(wdata, raw_q);
    res_load = load_hit ? (wdata & raw_q) : res_q;
    post_hit = post_valid && overlaps(post_vec, mask_n);
    res_post = post_hit ? merge_bits(res_load, post_vec) : res_load;
    res_n    = clear_valid ? strip_bits(res_post, clear_vec) : res_post;
    flag_n   = irq_q || load_hit || post_hit;
    if (clear_valid && (res_n == '0)) flag_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      res_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_n;
      res_q  <= res_n;
      irq_q  <= flag_n;
    end
  end

endmodule

// File: rtl/irq_misc_unit.sv
module irq_misc_unit
  import irq_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              set,
  output logic [DATA_W-1:0] misc_word,
  output logic              rtc_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)   rtc_q <= 1'b0;
    else if (set) rtc_q <= 1'b1;
    else if (clr) rtc_q <= 1'b0;
  end

  always_comb begin
    misc_word          = '0;
    misc_word[RTC_BIT] = rtc_q;
  end

endmodule

// File: rtl/irq_route_hub.sv
module irq_route_hub
  import irq_route_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [CPU_ID_W-1:0] bus_cpu,
  input  logic [1:0]          bus_size,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_err,
  input  logic                post_valid,
  input  logic [DATA_W-1:0]   post_vec,
  input  logic                clear_valid,
  input  logic [DATA_W-1:0]   clear_vec,
  input  logic                rtc_set,
  output logic [NCPU-1:0]     cpu_irq,
  output logic                rtc_irq
);

  localparam int LANE_W = (NCPU > 1) ? $clog2(NCPU) : 1;

  // named internal events, visible to the bound checker
  logic [DATA_W-1:0]            raw_q;
  logic [NCPU-1:0][DATA_W-1:0]  mask_q;
  logic [NCPU-1:0][DATA_W-1:0]  res_q;
  logic [NCPU-1:0]              irq_q;
  logic [NCPU-1:0]              load_hit;
  logic [NCPU-1:0]              post_hit;
  logic [NCPU-1:0]              mask_we;
  reg_kind_e                    kind;
  logic [LANE_W-1:0]            lane;
  logic                         acc_err;
  logic                         misc_clr;
  logic [DATA_W-1:0]            misc_word;
  logic                         rtc_q;
  logic [DATA_W-1:0]            rd_word;
  logic [DATA_W-1:0]            rdata_q;
  logic                         err_q;

  irq_bus_decode #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .wbit_rtc  (bus_wdata[RTC_BIT]),
    .kind      (kind),
    .lane      (lane),
    .acc_err   (acc_err),
    .mask_we   (mask_we),
    .misc_clr  (misc_clr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else begin
      raw_q <= strip_bits(merge_bits(raw_q, post_valid ? post_vec : '0),
                          clear_valid ? clear_vec : '0);
    end
  end

  for (genvar g = 0; g < NCPU; g++) begin : g_lane
    irq_cpu_lane u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .mask_we     (mask_we[g]),
      .wdata       (bus_wdata),
      .raw_q       (raw_q),
      .post_valid  (post_valid),
      .post_vec    (post_vec),
      .clear_valid (clear_valid),
      .clear_vec   (clear_vec),
      .mask_q      (mask_q[g]),
      .res_q       (res_q[g]),
      .irq_q       (irq_q[g]),
      .load_hit    (load_hit[g]),
      .post_hit    (post_hit[g])
    );
  end

  irq_misc_unit u_misc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (misc_clr),
    .set       (rtc_set),
    .misc_word (misc_word),
    .rtc_q     (rtc_q)
  );

  always_comb begin
    case (kind)
      K_MISC:  rd_word = misc_word | DATA_W'(bus_cpu);
      K_RAW:   rd_word = raw_q;
      K_MASK:  rd_word = mask_q[lane];
      K_RES:   rd_word = res_q[lane];
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q   <= acc_err;
      rdata_q <= (bus_valid && !bus_write && !acc_err) ? rd_word : '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
  assign cpu_irq   = irq_q;
  assign rtc_irq   = rtc_q;

endmodule

// File: rtl/irq_route_checker.sv
module irq_route_checker
  import irq_route_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_valid,
  input logic                       bus_write,
  input logic [1:0]                 bus_size,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic                       bus_err,
  input logic                       post_valid,
  input logic [DATA_W-1:0]          post_vec,
  input logic                       clear_valid,
  input logic                       rtc_set,
  input logic [NCPU-1:0]            cpu_irq,
  input logic                       rtc_irq,
  input logic [DATA_W-1:0]          raw_q,
  input logic [NCPU-1:0][DATA_W-1:0] mask_q
);

  localparam int IDX_W = ADDR_W - STRIDE_LSB;

  logic misc_clear_wr;
  assign misc_clear_wr = bus_valid && bus_write && (bus_size == SIZE_DWORD) &&
                         (bus_addr[ADDR_W-1:STRIDE_LSB] == IDX_W'(IDX_MISC)) &&
                         bus_wdata[RTC_BIT];

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (cpu_irq == '0) && !rtc_irq && (raw_q == '0));

  a_r2_narrow_err: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && (bus_size != SIZE_DWORD) |=> bus_err);

  a_r12_err_follows_access: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_valid));

  a_r12_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));

  a_r3_raw_only_by_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    !post_valid && !clear_valid |=> $stable(raw_q));

  a_r6_rtc_set: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_set |=> rtc_irq);

  a_r6_rtc_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
    misc_clear_wr && !rtc_set |=> !rtc_irq);

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    a_r8_post_raises: assert property (@(posedge clk) disable iff (!rst_n)
      post_valid && !bus_valid && !clear_valid && ((post_vec & mask_q[g]) != '0)
      |=> cpu_irq[g]);

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[g] && !clear_valid |=> cpu_irq[g]);

    a_r9_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_irq[g]) |-> $past(clear_valid));
  end

endmodule

bind irq_route_hub irq_route_checker #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_size    (bus_size),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .bus_err     (bus_err),
  .post_valid  (post_valid),
  .post_vec    (post_vec),
  .clear_valid (clear_valid),
  .rtc_set     (rtc_set),
  .cpu_irq     (cpu_irq),
  .rtc_irq     (rtc_irq),
  .raw_q       (raw_q),
  .mask_q      (mask_q)
);

// File: tb/irq_route_hub_test.sv
`timescale 1ns/1ps
module irq_route_hub_test;

  localparam int NCPU   = 4;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_valid = 1'b0;
  logic              bus_write = 1'b0;
  logic [1:0]        bus_cpu = '0;
  logic [1:0]        bus_size = 2'b11;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [63:0]       bus_wdata = '0;
  logic [63:0]       bus_rdata;
  logic              bus_err;
  logic              post_valid = 1'b0;
  logic [63:0]       post_vec = '0;
  logic              clear_valid = 1'b0;
  logic [63:0]       clear_vec = '0;
  logic              rtc_set = 1'b0;
  logic [NCPU-1:0]   cpu_irq;
  logic              rtc_irq;

  always #10 clk = ~clk;

  irq_route_hub #(.NCPU(NCPU), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_cpu(bus_cpu), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .post_valid(post_valid), .post_vec(post_vec), .clear_valid(clear_valid),
    .clear_vec(clear_vec), .rtc_set(rtc_set), .cpu_irq(cpu_irq), .rtc_irq(rtc_irq)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // reference model, updated from the requirements
  logic [63:0] m_raw = '0;
  logic [63:0] m_mask [NCPU];
  logic [63:0] m_res  [NCPU];
  logic        m_flag [NCPU];
  logic        m_rtc = 1'b0;

  typedef struct {
    logic        err;
    logic [63:0] rd;
    string       tag;
  } rsp_t;
  rsp_t exp_q[$];
  logic seen = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: compares each registered response against the queued expectation
  always @(posedge clk) seen <= bus_valid && rst_n;

  always @(negedge clk) begin : mon
    rsp_t e;
    if (seen) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12", "unexpected response", {63'b0, bus_err}, 64'b0);
      end else begin
        e = exp_q.pop_front();
        check(bus_err === e.err, e.tag, "err", {63'b0, bus_err}, {63'b0, e.err});
        check(bus_rdata === e.rd, e.tag, "rdata", bus_rdata, e.rd);
      end
    end
  end

  function automatic rsp_t expect_rsp(input bit w, input logic [1:0] cpu, input int idx,
                                      input logic [1:0] sz, input logic [63:0] wd);
    rsp_t r;
    r.err = 1'b0;
    r.rd  = '0;
    r.tag = "";
    if (sz != 2'b11) begin
      r.err = 1'b1;
    end else if (idx == 0) begin
      r.err = w;
    end else if (idx == 1) begin
      if (w) r.err = !wd[4];
      else   r.rd  = ({63'b0, m_rtc} << 4) | {62'b0, cpu};
    end else if (idx == 2) begin
      if (w) r.err = 1'b1; else r.rd = m_raw;
    end else if (idx >= 4 && idx < 4 + NCPU) begin
      if (!w) r.rd = m_mask[idx-4];
    end else if (idx >= 8 && idx < 8 + NCPU) begin
      if (w) r.err = 1'b1; else r.rd = m_res[idx-8];
    end else begin
      r.err = 1'b1;
    end
    return r;
  endfunction

  // driver: one cycle of stimulus, pushes the expected response, updates the model
  task automatic cyc(input bit bv, input bit w, input logic [1:0] cpu, input int idx,
                     input logic [1:0] sz, input logic [63:0] wd,
                     input bit pv, input logic [63:0] pvec,
                     input bit cv, input logic [63:0] cvec,
                     input bit rs, input string tag);
    rsp_t e;
    logic [63:0] raw0;
    @(negedge clk);
    bus_valid = bv; bus_write = w; bus_cpu = cpu; bus_size = sz;
    bus_addr = ADDR_W'(idx << 6); bus_wdata = wd;
    post_valid = pv; post_vec = pvec; clear_valid = cv; clear_vec = cvec;
    rtc_set = rs;
    e = expect_rsp(w, cpu, idx, sz, wd);
    e.tag = tag;
    if (bv) exp_q.push_back(e);
    raw0 = m_raw;
    if (bv && !e.err && w && idx >= 4 && idx < 4 + NCPU) begin
      m_mask[idx-4] = wd;
      if ((wd & raw0) != 0) begin
        m_res[idx-4]  = wd & raw0;
        m_flag[idx-4] = 1'b1;
      end
    end
    if (bv && !e.err && w && idx == 1) m_rtc = 1'b0;
    if (rs) m_rtc = 1'b1;
    if (pv) begin
      m_raw = m_raw | pvec;
      for (int i = 0; i < NCPU; i++) begin
        if ((pvec & m_mask[i]) != 0) begin
          m_res[i]  = m_res[i] | pvec;
          m_flag[i] = 1'b1;
        end
      end
    end
    if (cv) begin
      m_raw = m_raw & ~cvec;
      for (int i = 0; i < NCPU; i++) begin
        m_res[i] = m_res[i] & ~cvec;
        if (m_res[i] == 0) m_flag[i] = 1'b0;
      end
    end
    @(negedge clk);
    bus_valid = 1'b0; post_valid = 1'b0; clear_valid = 1'b0; rtc_set = 1'b0;
  endtask

  task automatic rd(input logic [1:0] cpu, input int idx, input string tag);
    cyc(1, 0, cpu, idx, 2'b11, '0, 0, '0, 0, '0, 0, tag);
  endtask

  task automatic wr(input int idx, input logic [63:0] wd, input string tag);
    cyc(1, 1, 2'b00, idx, 2'b11, wd, 0, '0, 0, '0, 0, tag);
  endtask

  task automatic post(input logic [63:0] v, input string tag);
    cyc(0, 0, 2'b00, 0, 2'b11, '0, 1, v, 0, '0, 0, tag);
  endtask

  task automatic clr(input logic [63:0] v, input string tag);
    cyc(0, 0, 2'b00, 0, 2'b11, '0, 0, '0, 1, v, 0, tag);
  endtask

  task automatic check_lines(input string tag);
    logic [NCPU-1:0] exp_irq;
    for (int i = 0; i < NCPU; i++) exp_irq[i] = m_flag[i];
    check(cpu_irq === exp_irq, tag, "cpu_irq", 64'(cpu_irq), 64'(exp_irq));
    check(rtc_irq === m_rtc, tag, "rtc_irq", 64'(rtc_irq), 64'(m_rtc));
  endtask

  task automatic check_regs(input string tag);
    rd(2'b00, 2, tag);
    for (int i = 0; i < NCPU; i++) begin
      rd(2'b00, 4 + i, tag);
      rd(2'b00, 8 + i, tag);
    end
  endtask

  task automatic err_gap(input string tag);
    @(negedge clk);
    check(bus_err === 1'b0, tag, "err not single cycle", 64'(bus_err), 64'b0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 64'b0, 64'b1);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NCPU; i++) begin
      m_mask[i] = '0; m_res[i] = '0; m_flag[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    check_lines("R1");
    rst_n = 1'b1;
    check_regs("R1");

    // R2: narrow accesses rejected, no state change
    cyc(1, 1, 2'b00, 4, 2'b10, 64'hFF, 0, '0, 0, '0, 0, "R2");
    err_gap("R12");
    cyc(1, 0, 2'b00, 2, 2'b00, '0, 0, '0, 0, '0, 0, "R2");
    rd(2'b00, 4, "R2");

    // R3, R4, R12: read-only and unknown registers
    rd(2'b01, 0, "R4");
    wr(0, 64'h1, "R3");
    wr(2, 64'hFFFF, "R3");
    wr(9, 64'h5, "R3");
    rd(2'b00, 3, "R12");
    wr(12, 64'h7, "R12");
    rd(2'b00, 63, "R12");
    check_regs("R3");

    // R5, R6: misc register and RTC
    rd(2'b10, 1, "R5");
    cyc(0, 0, 2'b00, 0, 2'b11, '0, 0, '0, 0, '0, 1, "R6");
    check_lines("R6");
    rd(2'b01, 1, "R5");
    wr(1, 64'h20, "R6");
    check_lines("R6");
    wr(1, 64'h10, "R6");
    check_lines("R6");
    rd(2'b11, 1, "R5");
    cyc(0, 0, 2'b00, 0, 2'b11, '0, 0, '0, 0, '0, 1, "R6");
    cyc(1, 1, 2'b00, 1, 2'b11, 64'h10, 0, '0, 0, '0, 1, "R6");
    check_lines("R6");
    wr(1, 64'h10, "R6");
    check_lines("R6");

    // R8 with no masks, then R7 mask writes
    post(64'hFF, "R8");
    check_lines("R8");
    wr(4, 64'h0F, "R7");
    check_lines("R7");
    wr(5, 64'hF00, "R7");
    check_lines("R7");
    check_regs("R7");

    // R8: overlapping posts merge the whole vector
    post(64'h300, "R8");
    check_lines("R8");
    post(64'h1_0000_0001, "R8");
    check_lines("R8");
    check_regs("R8");

    // R9, R10: clears and sticky flags
    clr(64'h3, "R10");
    check_lines("R10");
    clr(64'h1_0000_000C, "R9");
    check_lines("R9");
    wr(5, 64'h0, "R10");
    check_lines("R10");
    clr(64'h100, "R10");
    check_lines("R10");
    clr(64'h200, "R9");
    check_lines("R9");
    check_regs("R9");

    // R11: same-cycle ordering
    cyc(1, 1, 2'b00, 7, 2'b11, 64'hF0F0, 1, 64'hF000, 1, 64'hF0F0, 0, "R11");
    check_lines("R11");
    cyc(1, 1, 2'b00, 6, 2'b11, 64'h1, 1, 64'h1, 0, '0, 0, "R11");
    check_lines("R11");
    check_regs("R11");
    clr(64'h1, "R9");
    check_lines("R9");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R12", "responses outstanding", 64'(exp_q.size()), 64'b0);
    summary();
    $finish;
  end

endmodule